// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address when the translation cache has missed. It walks a two-level hierarchy. The upper ten address bits select a word in the page directory, whose base comes from a per-process base input. The next ten bits select a word in the page table that the directory word points to. The low twelve bits pass through unchanged as the offset into a 4 KB page. A directory word therefore spans 4 MB, and both page tables and pages are 4 KB.

Each 32-bit entry holds a 4 KB-aligned frame number in bits [31:12] and flags in the low bits:

| Bit | Flag |
|-----|------|
| 0 | present |
| 1 | writable |
| 2 | user-accessible |
| 3 | write-through (ignored by the walker) |
| 4 | cache-disable (ignored by the walker) |
| 5 | accessed |
| 6 | dirty |
| 11:9 | free for system software (ignored by the walker) |

At each level the walker checks presence and the access rights. It then sets the accessed flag, and on a write it also sets the dirty flag in the leaf entry. It writes an entry back to memory only when one of those flags actually changes. The result is either a physical address or a fault code.

All three data paths use valid/ready handshakes:

- **Walk request** (`walk_valid`/`walk_ready`): accepted only when the walker is idle.
- **Memory request** (`mem_valid`/`mem_ready`): address, direction and write data stay stable until `mem_ready`. A read returns its word later with a single-cycle `rdata_valid` strobe, which has no back-pressure. A write completes at its handshake.
- **Result** (`done_valid`/`done_ready`): held stable until `done_ready`, and the next walk is not accepted before then.

Top module: `pt_walker`

## Requirements
- R1: The directory read address is {base[31:12], va[31:22], 2'b00}. The table read address is {directory_entry[31:12], va[21:12], 2'b00}.
- R2: A walk that does not fault returns {table_entry[31:12], va[11:0]} with `done_fault` low.
- R3: If the present flag (bit 0) is clear at either level, the walk ends in a fault.
- R4: A user access (`walk_user`=1) faults if the user flag (bit 2) is clear at the level being checked.
- R5: A user write faults if the writable flag (bit 1) is clear at the level being checked. A supervisor write succeeds regardless of that flag.
- R6: When an entry passes its check and its accessed flag (bit 5) is clear, the entry is written back with that flag set. No write is issued when nothing changes.
- R7: On a successful write access, the dirty flag (bit 6) is set and written back in the table entry only. It is never set in a directory entry.
- R8: The fault code `done_code` has four bits:
  - bit 0 is the present flag of the faulting entry;
  - bit 1 is the write flag of the access;
  - bit 2 is the user flag of the access;
  - bit 3 is 1 when the table level faulted and 0 when the directory level faulted.
  
  `done_code` is 0 when there is no fault.
- R9: `walk_ready` is high only when idle, with no memory request or result pending. A memory request stays stable until accepted. A result stays stable until accepted.
- R10: After a fault, `done_addr` is 0 and no further memory access is made for that walk.
- R11: The directory base is sampled when a walk is accepted. Changing `dir_base` during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 32 | Base address of the current page directory |
| walk_valid | input | 1 | Walk request valid |
| walk_ready | output | 1 | Walker idle, request accepted |
| walk_va | input | 32 | Linear address to translate |
| walk_write | input | 1 | Access is a write |
| walk_user | input | 1 | Access is from user mode |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated entry for write-back |
| rdata_valid | input | 1 | Read data strobe |
| rdata | input | 32 | Entry read from memory |
| done_valid | output | 1 | Result valid |
| done_ready | input | 1 | Result accepted |
| done_fault | output | 1 | Walk ended in a fault |
| done_code | output | 4 | Fault code (R8) |
| done_addr | output | 32 | Physical address, 0 on fault |

## Verification
The hardest situations to reach are the ones where flags change in memory as a side effect. The entry must pass its check with the accessed or dirty flag clear, and the walk must then make exactly one write-back with the right word.

The stimulus sets up a bench memory whose entries deliberately lack these flags. It then walks addresses in an order where an earlier walk changes what a later one sees. Afterwards it reads the memory words and the write count back.

The memory side stalls `mem_ready` on a fixed pattern, so each request is held across rejected cycles. One directed walk changes `dir_base` right after acceptance to show the latched base is used.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Flag positions inside an entry
  localparam int FL_PRESENT = 0;
  localparam int FL_WRITE   = 1;
  localparam int FL_USER    = 2;
  localparam int FL_ACCESS  = 5;
  localparam int FL_DIRTY   = 6;

  // Fault code bit positions
  localparam int FC_PRESENT = 0;
  localparam int FC_WRITE   = 1;
  localparam int FC_USER    = 2;
  localparam int FC_LEVEL   = 3;
  localparam int FC_W       = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WAIT,
    ST_DIR_CHK,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WAIT,
    ST_TBL_CHK,
    ST_TBL_WB,
    ST_DONE
  } walk_state_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]        index,
  output logic [ADDR_W-1:0]       addr
);
  // entries are packed words; the low bits give the byte offset of a word
  localparam int BYTE_W = OFF_W - IDX_W;

  assign addr = {frame, index, {BYTE_W{1'b0}}};
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int  ENT_W = 32,
  parameter bit  LEAF  = 1'b0
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  output logic             fault,
  output logic [ENT_W-1:0] updated,
  output logic             changed
);
  logic no_user, no_write;

  assign no_user  = is_user && !entry[FL_USER];
  assign no_write = is_user && is_write && !entry[FL_WRITE];
  assign fault    = !entry[FL_PRESENT] || no_user || no_write;

  generate
    if (LEAF) begin : g_leaf
      always_comb begin
        updated = entry;
        updated[FL_ACCESS] = 1'b1;
        if (is_write) updated[FL_DIRTY] = 1'b1;
      end
    end else begin : g_upper
      always_comb begin
        updated = entry;
        updated[FL_ACCESS] = 1'b1;
      end
    end
  endgenerate

  assign changed = (updated != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int DIR_IDX_W = 10,
  parameter int TBL_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              walk_valid,
  output logic              walk_ready,
  input  logic [ADDR_W-1:0] walk_va,
  input  logic              walk_write,
  input  logic              walk_user,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              rdata_valid,
  input  logic [ADDR_W-1:0] rdata,
  output logic              done_valid,
  input  logic              done_ready,
  output logic              done_fault,
  output logic [FC_W-1:0]   done_code,
  output logic [ADDR_W-1:0] done_addr
);
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int TBL_LO  = OFF_W;
  localparam int DIR_LO  = OFF_W + TBL_IDX_W;

  walk_state_e            state;
  logic [ADDR_W-1:0]      va_q;
  logic                   wr_q, us_q;
  logic [FRAME_W-1:0]     base_q, tbase_q;
  logic [ADDR_W-1:0]      ent_q;
  logic                   flt_q;
  logic [FC_W-1:0]        code_q;

  logic [ADDR_W-1:0]      dir_addr, tbl_addr;
  logic                   dir_fault, dir_chg, tbl_fault, tbl_chg;
  logic [ADDR_W-1:0]      dir_upd, tbl_upd;

  pt_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(DIR_IDX_W)) u_dir_addr (
    .frame (base_q),
    .index (va_q[DIR_LO +: DIR_IDX_W]),
    .addr  (dir_addr)
  );

  pt_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(TBL_IDX_W)) u_tbl_addr (
    .frame (tbase_q),
    .index (va_q[TBL_LO +: TBL_IDX_W]),
    .addr  (tbl_addr)
  );

  pt_entry_check #(.ENT_W(ADDR_W), .LEAF(1'b0)) u_dir_chk (
    .entry    (ent_q),
    .is_write (wr_q),
    .is_user  (us_q),
    .fault    (dir_fault),
    .updated  (dir_upd),
    .changed  (dir_chg)
  );

  pt_entry_check #(.ENT_W(ADDR_W), .LEAF(1'b1)) u_tbl_chk (
    .entry    (ent_q),
    .is_write (wr_q),
    .is_user  (us_q),
    .fault    (tbl_fault),
    .updated  (tbl_upd),
    .changed  (tbl_chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      us_q    <= 1'b0;
      base_q  <= '0;
      tbase_q <= '0;
      ent_q   <= '0;
      flt_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (walk_valid) begin
          va_q   <= walk_va;
          wr_q   <= walk_write;
          us_q   <= walk_user;
          base_q <= dir_base[ADDR_W-1:OFF_W];
          flt_q  <= 1'b0;
          code_q <= '0;
          state  <= ST_DIR_RD;
        end
        ST_DIR_RD:   if (mem_ready) state <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (rdata_valid) begin
          ent_q <= rdata;
          state <= ST_DIR_CHK;
        end
        ST_DIR_CHK: begin
          if (dir_fault) begin
            flt_q  <= 1'b1;
            code_q <= {1'b0, us_q, wr_q, ent_q[FL_PRESENT]};
            state  <= ST_DONE;
          end else begin
            tbase_q <= ent_q[ADDR_W-1:OFF_W];
            if (dir_chg) begin
              ent_q <= dir_upd;
              state <= ST_DIR_WB;
            end else begin
              state <= ST_TBL_RD;
            end
          end
        end
        ST_DIR_WB:   if (mem_ready) state <= ST_TBL_RD;
        ST_TBL_RD:   if (mem_ready) state <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (rdata_valid) begin
          ent_q <= rdata;
          state <= ST_TBL_CHK;
        end
        ST_TBL_CHK: begin
          if (tbl_fault) begin
            flt_q  <= 1'b1;
            code_q <= {1'b1, us_q, wr_q, ent_q[FL_PRESENT]};
            state  <= ST_DONE;
          end else if (tbl_chg) begin
            ent_q <= tbl_upd;
            state <= ST_TBL_WB;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_TBL_WB: if (mem_ready) state <= ST_DONE;
        ST_DONE:   if (done_ready) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign walk_ready = (state == ST_IDLE);
  assign mem_valid  = (state == ST_DIR_RD) || (state == ST_DIR_WB) ||
                      (state == ST_TBL_RD) || (state == ST_TBL_WB);
  assign mem_we     = (state == ST_DIR_WB) || (state == ST_TBL_WB);
  assign mem_addr   = ((state == ST_DIR_RD) || (state == ST_DIR_WB)) ? dir_addr : tbl_addr;
  assign mem_wdata  = ent_q;

  assign done_valid = (state == ST_DONE);
  assign done_fault = flt_q;
  assign done_code  = flt_q ? code_q : '0;
  assign done_addr  = flt_q ? '0 : {ent_q[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              walk_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic              done_valid,
  input logic              done_ready,
  input logic              done_fault,
  input logic [FC_W-1:0]   done_code,
  input logic [ADDR_W-1:0] done_addr
);
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable(done_addr) && $stable(done_code) && $stable(done_fault));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_valid && !done_valid);

  a_r6_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[FL_ACCESS] && mem_wdata[FL_PRESENT]);

  a_r10_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_addr == '0);

  a_r8_clean_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_fault |-> done_code == '0);

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_pt_walker_chk (.*);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dir_base = 32'h0000_1000;
  logic        walk_valid = 1'b0;
  logic        walk_ready;
  logic [31:0] walk_va = '0;
  logic        walk_write = 1'b0;
  logic        walk_user = 1'b0;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic        rdata_valid = 1'b0;
  logic [31:0] rdata = '0;
  logic        done_valid, done_fault;
  logic        done_ready = 1'b1;
  logic [3:0]  done_code;
  logic [31:0] done_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] mem [0:4095];
  int          rd_total = 0;
  int          wr_total = 0;
  logic [31:0] rd_log [0:7];
  int          stall_cnt = 0;

  always #5 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .walk_valid(walk_valid), .walk_ready(walk_ready), .walk_va(walk_va),
    .walk_write(walk_write), .walk_user(walk_user),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rdata_valid(rdata_valid), .rdata(rdata),
    .done_valid(done_valid), .done_ready(done_ready), .done_fault(done_fault),
    .done_code(done_code), .done_addr(done_addr)
  );

  // memory model: stalls every third cycle, answers reads one cycle later
  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 1;
    mem_ready <= (stall_cnt % 3) != 0;
  end

  always @(posedge clk) begin
    rdata_valid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_total <= wr_total + 1;
      end else begin
        rdata_valid <= 1'b1;
        rdata <= mem[mem_addr[13:2]];
        rd_log[rd_total % 8] <= mem_addr;
        rd_total <= rd_total + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one walk; hold = cycles to withhold done_ready; swap changes dir_base after acceptance
  task automatic walk(input logic [31:0] va, input logic wr, input logic us, input int hold,
                      input bit swap, output logic flt, output logic [3:0] code,
                      output logic [31:0] pa);
    int t;
    @(negedge clk);
    while (!walk_ready) @(negedge clk);
    walk_valid = 1'b1; walk_va = va; walk_write = wr; walk_user = us;
    done_ready = (hold == 0);
    @(negedge clk);
    walk_valid = 1'b0;
    if (swap) dir_base = 32'h0000_0000;
    t = 0;
    while (!done_valid && t < 2000) begin @(negedge clk); t++; end
    if (!done_valid) check(1'b0, "watchdog walk timeout", 32'(t), 32'd0);
    flt = done_fault; code = done_code; pa = done_addr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(done_valid && done_addr == pa && done_code == code && !walk_ready,
            "R9 result held", done_addr, pa);
    end
    done_ready = 1'b1;
    @(negedge clk);
    dir_base = 32'h0000_1000;
  endtask

  // va, write, user, fault, code, paddr
  localparam logic [70:0] VEC [0:10] = '{
    {32'h0040_0123, 1'b0, 1'b1, 1'b0, 4'd0,  32'hABCD_E123},
    {32'h0040_2000, 1'b0, 1'b0, 1'b1, 4'd8,  32'h0},
    {32'h00C0_0000, 1'b1, 1'b1, 1'b1, 4'd6,  32'h0},
    {32'h0100_0000, 1'b0, 1'b1, 1'b1, 4'd5,  32'h0},
    {32'h0100_0FFF, 1'b1, 1'b0, 1'b0, 4'd0,  32'hABCD_EFFF},
    {32'h0080_0000, 1'b1, 1'b1, 1'b1, 4'd7,  32'h0},
    {32'h0080_0010, 1'b1, 1'b0, 1'b0, 4'd0,  32'h7777_7010},
    {32'h0040_3000, 1'b1, 1'b1, 1'b1, 4'd15, 32'h0},
    {32'h0040_4000, 1'b0, 1'b1, 1'b1, 4'd13, 32'h0},
    {32'h0040_4444, 1'b1, 1'b0, 1'b0, 4'd0,  32'h6666_6444},
    {32'h0040_1008, 1'b0, 1'b1, 1'b0, 4'd0,  32'h1234_5008}
  };

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic flt; logic [3:0] code; logic [31:0] pa;
    int r0, w0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h401] = 32'h0000_2027;  // dir 1: table 0x2000, P RW US A
    mem[12'h402] = 32'h0000_3005;  // dir 2: table 0x3000, P US
    mem[12'h404] = 32'h0000_2023;  // dir 4: table 0x2000, P RW A, supervisor
    mem[12'h800] = 32'hABCD_E067;
    mem[12'h801] = 32'h1234_5007;
    mem[12'h803] = 32'h5555_5025;
    mem[12'h804] = 32'h6666_6023;
    mem[12'hC00] = 32'h7777_7027;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(walk_ready && !mem_valid && !done_valid, "R9 reset idle", {29'd0, walk_ready, mem_valid, done_valid}, 32'd4);

    for (int i = 0; i < 11; i++) begin
      walk(VEC[i][70:39], VEC[i][38], VEC[i][37], 0, 1'b0, flt, code, pa);
      check(flt == VEC[i][36], $sformatf("R3 R4 R5 fault flag vector %0d", i), {31'd0, flt}, {31'd0, VEC[i][36]});
      check(code == VEC[i][35:32], $sformatf("R8 code vector %0d", i), {28'd0, code}, {28'd0, VEC[i][35:32]});
      check(pa == VEC[i][31:0], $sformatf("R2 R10 address vector %0d", i), pa, VEC[i][31:0]);
    end

    // R6 R7: write-backs only where flags changed
    check(wr_total == 4, "R6 write-back count", 32'(wr_total), 32'd4);
    check(mem[12'h402] == 32'h0000_3025, "R7 directory gets accessed but not dirty", mem[12'h402], 32'h0000_3025);
    check(mem[12'hC00] == 32'h7777_7067, "R7 leaf dirty on write", mem[12'hC00], 32'h7777_7067);
    check(mem[12'h804] == 32'h6666_6063, "R7 leaf accessed and dirty", mem[12'h804], 32'h6666_6063);
    check(mem[12'h801] == 32'h1234_5027, "R6 leaf accessed on read", mem[12'h801], 32'h1234_5027);
    check(mem[12'h401] == 32'h0000_2027, "R6 unchanged entry", mem[12'h401], 32'h0000_2027);
    check(mem[12'h803] == 32'h5555_5025, "R5 faulting entry untouched", mem[12'h803], 32'h5555_5025);

    // R1: entry addresses, no writes when flags are already set
    r0 = rd_total; w0 = wr_total;
    walk(32'h0040_1abc, 1'b0, 1'b0, 0, 1'b0, flt, code, pa);
    check(rd_total - r0 == 2, "R1 two reads", 32'(rd_total - r0), 32'd2);
    check(rd_log[r0 % 8] == 32'h0000_1004, "R1 directory address", rd_log[r0 % 8], 32'h0000_1004);
    check(rd_log[(r0 + 1) % 8] == 32'h0000_2004, "R1 table address", rd_log[(r0 + 1) % 8], 32'h0000_2004);
    check(wr_total == w0, "R6 no write when set", 32'(wr_total - w0), 32'd0);

    // R10: fault at directory stops the walk after one read
    r0 = rd_total; w0 = wr_total;
    walk(32'h00C0_0000, 1'b0, 1'b0, 0, 1'b0, flt, code, pa);
    check(rd_total - r0 == 1 && wr_total == w0, "R10 single read after fault", 32'(rd_total - r0), 32'd1);
    check(flt && code == 4'd0, "R3 directory not present", {27'd0, flt, code}, 32'h10);

    // R11: base change after acceptance is ignored
    walk(32'h0040_0456, 1'b0, 1'b1, 0, 1'b1, flt, code, pa);
    check(!flt && pa == 32'hABCD_E456, "R11 latched base", pa, 32'hABCD_E456);

    // R9: result held under back-pressure
    walk(32'h0080_0020, 1'b0, 1'b1, 3, 1'b0, flt, code, pa);
    check(!flt && pa == 32'h7777_7020, "R9 held result value", pa, 32'h7777_7020);

    // R5: supervisor write through read-only leaf succeeds
    walk(32'h0040_3008, 1'b1, 1'b0, 0, 1'b0, flt, code, pa);
    check(!flt && pa == 32'h5555_5008, "R5 supervisor ignores writable", pa, 32'h5555_5008);
    check(mem[12'h803] == 32'h5555_5065, "R7 supervisor write sets dirty", mem[12'h803], 32'h5555_5065);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule